// File: doc/BRIEF.md
# Loop Bandwidth Step-Down Sequencer

This block controls the fast-lock phase of a frequency synthesizer loop. Each write of a new frequency produces a one-cycle start pulse. The pulse puts the loop into its wide-bandwidth state: high charge-pump current, and both loop-filter resistor switches closed. Two down-counters then run on the phase-detector reference clock. When the first one expires, the charge-pump current drops to its normal value. When the second one expires, both switches open, which narrows the loop.

Each timeout is a separately programmed 10-bit value, and the two events may happen in either order. The block reads the timeout inputs only on the start pulse. A new start pulse during a sequence reloads both counters and puts the outputs back into the wide-bandwidth state. A busy flag covers the whole sequence.

Top module: `bw_step_sequencer`

## Requirements
- R1: After reset, cpFastOn is 0, swACloseOn and swBCloseOn are 0 (switches open), and seqBusy is 0.
- R2: On the reference edge that samples startPulse high, cpFastOn, swACloseOn, swBCloseOn and seqBusy all become 1. A value of 1 on a switch output means that switch is closed.
- R3: cpFastOn falls on the (cpTimeout+1)-th reference edge after the start edge. A cpTimeout of 0 means it falls on the first edge after the start edge.
- R4: swACloseOn and swBCloseOn fall together on the (swTimeout+1)-th reference edge after the start edge, and they are always equal.
- R5: The two events are independent, so either may come first. Equal timeouts make both events happen on the same edge.
- R6: seqBusy stays 1 from the start edge until the later of the two events, and falls on that same edge.
- R7: A start pulse while a sequence runs reloads both counters from the present timeout inputs and returns every output to the wide-bandwidth state. This holds even on the edge where a counter would have expired.
- R8: The timeout inputs are sampled only on the start edge. Changing them while a sequence runs has no effect on event timing.
- R9: While no sequence runs, the outputs hold the narrow-bandwidth state (all 0) whatever the timeout inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Phase-detector reference clock; one count per cycle |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle pulse from the frequency-register write |
| cpTimeout | input | 10 | Reference cycles before the charge-pump current drops |
| swTimeout | input | 10 | Reference cycles before the filter switches open |
| cpFastOn | output | 1 | 1 selects the high fast-lock charge-pump current |
| swACloseOn | output | 1 | 1 closes the first loop-filter resistor switch |
| swBCloseOn | output | 1 | 1 closes the second loop-filter resistor switch |
| seqBusy | output | 1 | High while a bandwidth step-down sequence is in progress |

## Verification
A wrong counter load or a wrong decrement shows up at the ports as an event edge that comes one or more reference cycles early or late. The bench therefore compares every output on every cycle of each sequence, so a fault becomes visible on the cycle where the first event should happen. A pending-event flag that stays stuck shows up either as seqBusy never falling or as a switch output that never opens, and a full expected window exposes both. Restart and input-change faults show up as event timing that follows the old values; the bench catches them within the shortened window that follows the restart.

// File: rtl/bw_step_pkg.sv
package bw_step_pkg;
  localparam int NUM_EVT = 2;
  localparam int EVT_CP  = 0;
  localparam int EVT_SW  = 1;

  typedef struct packed {
    logic               load;
    logic [NUM_EVT-1:0] dec;
  } seqStrobeT;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqStateT;
endpackage

// File: rtl/bw_step_datapath.sv
module bw_step_datapath
  import bw_step_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  seqStrobeT                     strobe,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] loadVal,
  output logic [NUM_EVT-1:0]            zeroFlag
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_timer
    logic [CNT_W-1:0] countQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        countQ <= '0;
      end else if (strobe.load) begin
        countQ <= loadVal[i];
      end else if (strobe.dec[i]) begin
        countQ <= countQ - ONE;
      end
    end

    assign zeroFlag[i] = (countQ == '0);
  end
endmodule

// File: rtl/bw_step_control.sv
module bw_step_control
  import bw_step_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [NUM_EVT-1:0] zeroFlag,
  output seqStrobeT          strobe,
  output logic [NUM_EVT-1:0] pending,
  output logic               busy
);
  seqStateT           stateQ, stateD;
  logic [NUM_EVT-1:0] pendingQ, pendingD;

  always_comb begin
    strobe.load = startPulse;
    strobe.dec  = '0;
    pendingD    = pendingQ;
    stateD      = stateQ;
    if (startPulse) begin
      pendingD = '1;
      stateD   = SEQ_RUN;
    end else if (stateQ == SEQ_RUN) begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (pendingQ[i]) begin
          if (zeroFlag[i]) pendingD[i] = 1'b0;
          else             strobe.dec[i] = 1'b1;
        end
      end
      if (pendingD == '0) stateD = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= SEQ_IDLE;
      pendingQ <= '0;
    end else begin
      stateQ   <= stateD;
      pendingQ <= pendingD;
    end
  end

  assign pending = pendingQ;
  assign busy    = (stateQ == SEQ_RUN);
endmodule

// File: rtl/bw_step_sequencer.sv
module bw_step_sequencer
  import bw_step_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] cpTimeout,
  input  logic [CNT_W-1:0] swTimeout,
  output logic             cpFastOn,
  output logic             swACloseOn,
  output logic             swBCloseOn,
  output logic             seqBusy
);
  seqStrobeT                     strobe;
  logic [NUM_EVT-1:0]            zeroFlag;
  logic [NUM_EVT-1:0]            pending;
  logic [NUM_EVT-1:0][CNT_W-1:0] loadVal;

  assign loadVal[EVT_CP] = cpTimeout;
  assign loadVal[EVT_SW] = swTimeout;

  bw_step_datapath #(.CNT_W(CNT_W)) datapath_i (
    .clk      (refClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadVal  (loadVal),
    .zeroFlag (zeroFlag)
  );

  bw_step_control control_i (
    .clk        (refClk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .zeroFlag   (zeroFlag),
    .strobe     (strobe),
    .pending    (pending),
    .busy       (seqBusy)
  );

  assign cpFastOn   = pending[EVT_CP];
  assign swACloseOn = pending[EVT_SW];
  assign swBCloseOn = pending[EVT_SW];
endmodule

// File: rtl/bw_step_checker.sv
module bw_step_checker #(
  parameter int CNT_W = 10
) (
  input logic             refClk,
  input logic             rstN,
  input logic             startPulse,
  input logic [CNT_W-1:0] cpTimeout,
  input logic [CNT_W-1:0] swTimeout,
  input logic             cpFastOn,
  input logic             swACloseOn,
  input logic             swBCloseOn,
  input logic             seqBusy
);
  logic [CNT_W:0]   sinceStart;
  logic [CNT_W-1:0] cpLat, swLat;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sinceStart <= '0;
      cpLat      <= '0;
      swLat      <= '0;
    end else if (startPulse) begin
      sinceStart <= '0;
      cpLat      <= cpTimeout;
      swLat      <= swTimeout;
    end else if (sinceStart != '1) begin
      sinceStart <= sinceStart + 1'b1;
    end
  end

  assert_start_wide_R2: assert property (@(posedge refClk) disable iff (!rstN)
    startPulse |=> (cpFastOn && swACloseOn && swBCloseOn && seqBusy));

  assert_cp_not_late_R3: assert property (@(posedge refClk) disable iff (!rstN)
    cpFastOn |-> (sinceStart <= {1'b0, cpLat}));

  assert_cp_not_early_R3: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(cpFastOn) |-> (sinceStart == {1'b0, cpLat} + 1'b1));

  assert_sw_not_late_R4: assert property (@(posedge refClk) disable iff (!rstN)
    swACloseOn |-> (sinceStart <= {1'b0, swLat}));

  assert_sw_not_early_R4: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(swACloseOn) |-> (sinceStart == {1'b0, swLat} + 1'b1));

  assert_sw_pair_R4: assert property (@(posedge refClk) disable iff (!rstN)
    swACloseOn == swBCloseOn);

  assert_busy_cover_R6: assert property (@(posedge refClk) disable iff (!rstN)
    seqBusy == (cpFastOn || swACloseOn));

  assert_idle_narrow_R9: assert property (@(posedge refClk) disable iff (!rstN)
    ($rose(cpFastOn) || $rose(swACloseOn)) |-> $past(startPulse));
endmodule

bind bw_step_sequencer bw_step_checker #(.CNT_W(CNT_W)) checker_i (
  .refClk     (refClk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .cpTimeout  (cpTimeout),
  .swTimeout  (swTimeout),
  .cpFastOn   (cpFastOn),
  .swACloseOn (swACloseOn),
  .swBCloseOn (swBCloseOn),
  .seqBusy    (seqBusy)
);

// File: tb/bw_step_sequencer_tb.sv
module bw_step_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int WATCHDOG   = 150000;

  logic             refClk = 1'b0;
  logic             rstN   = 1'b0;
  logic             startPulse = 1'b0;
  logic [CNT_W-1:0] cpTimeout = '0;
  logic [CNT_W-1:0] swTimeout = '0;
  logic             cpFastOn, swACloseOn, swBCloseOn, seqBusy;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #(CLK_PERIOD/2) refClk = ~refClk;

  bw_step_sequencer #(.CNT_W(CNT_W)) dut_i (
    .refClk     (refClk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .cpTimeout  (cpTimeout),
    .swTimeout  (swTimeout),
    .cpFastOn   (cpFastOn),
    .swACloseOn (swACloseOn),
    .swBCloseOn (swBCloseOn),
    .seqBusy    (seqBusy)
  );

  task automatic checkBit(input logic act, input logic exp, input string req, input string what);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Pulse start at a falling edge; returns at the falling edge after the load edge (sample index 0).
  task automatic pulseStart(input int cp, input int sw);
    cpTimeout  = CNT_W'(cp);
    swTimeout  = CNT_W'(sw);
    startPulse = 1'b1;
    @(negedge refClk);
    startPulse = 1'b0;
  endtask

  // Sample index j counts edges after the start edge: cp high while j <= cp, switches closed while j <= sw.
  task automatic checkWindow(input int cp, input int sw, input int n, input string req);
    for (int j = 0; j < n; j++) begin
      int later;
      later = (cp > sw) ? cp : sw;
      checkBit(cpFastOn,   (j <= cp),    {req, " R3"}, "cpFastOn");
      checkBit(swACloseOn, (j <= sw),    {req, " R4"}, "swACloseOn");
      checkBit(swBCloseOn, (j <= sw),    {req, " R4"}, "swBCloseOn");
      checkBit(seqBusy,    (j <= later), {req, " R6"}, "seqBusy");
      @(negedge refClk);
    end
  endtask

  task automatic checkIdle(input string req);
    checkBit(cpFastOn,   1'b0, req, "cpFastOn idle");
    checkBit(swACloseOn, 1'b0, req, "swACloseOn idle");
    checkBit(swBCloseOn, 1'b0, req, "swBCloseOn idle");
    checkBit(seqBusy,    1'b0, req, "seqBusy idle");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge refClk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge refClk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge refClk);
    checkIdle("R1");

    // R9: timeout inputs wiggle with no start; outputs stay narrow
    for (int k = 0; k < 4; k++) begin
      cpTimeout = CNT_W'(k * 5);
      swTimeout = CNT_W'(k * 3 + 1);
      @(negedge refClk);
      checkIdle("R9");
    end

    // R2 R3 R4 R5 R6: sweep both timeouts over 0..7, either order and equal
    for (int cp = 0; cp < 8; cp++) begin
      for (int sw = 0; sw < 8; sw++) begin
        pulseStart(cp, sw);
        checkBit(cpFastOn && swACloseOn && swBCloseOn && seqBusy, 1'b1, "R2", "wide after start");
        checkWindow(cp, sw, ((cp > sw) ? cp : sw) + 3, "R5");
        checkIdle("R9");
      end
    end

    // R3: largest counts
    pulseStart(1023, 1000);
    checkWindow(1023, 1000, 1026, "R3 max");

    // R8: inputs change right after start
    pulseStart(6, 9);
    cpTimeout = CNT_W'(1);
    swTimeout = CNT_W'(40);
    checkWindow(6, 9, 12, "R8");

    // R7: restart mid-sequence with new values
    pulseStart(10, 20);
    checkWindow(10, 20, 5, "R7 first");
    pulseStart(3, 2);
    checkWindow(3, 2, 6, "R7 restart");

    // R7: restart on the edge where the charge-pump counter would expire
    pulseStart(2, 4);
    checkWindow(2, 4, 2, "R7 pre");
    pulseStart(5, 1);
    checkWindow(5, 1, 8, "R7 collide");

    // R7: restart after the earlier event already happened
    pulseStart(1, 6);
    checkWindow(1, 6, 4, "R7 partial");
    pulseStart(4, 0);
    checkWindow(4, 0, 7, "R7 reclose");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule